// File: doc/BRIEF.md
# Sub-Cycle Delta-Sigma PWM Modulator

This block turns a fine-resolution digital demand into a single-bit pulse stream for a slow, high-resolution digital-to-analog converter built from an external low-pass filter. Time is split into short sub-cycles of a fixed number of clocks. Each sub-cycle carries one plain pulse, high from the start of the sub-cycle for a chosen number of clocks and low for the rest.

A first-order delta-sigma accumulator chooses each pulse width. Take a group of consecutive sub-cycles whose count is a power of two. Over such a group, the total high time equals the demand plus a fixed offset of one clock per sub-cycle. This gives a resolution finer than one sub-cycle step.

Every width lies between 1 clock and the sub-cycle length minus 1. So each sub-cycle has exactly one rising and one falling edge, and the error from switching stays the same whatever the demand. The demand is read once per sub-cycle, on the sub-cycle's last clock. Values above the largest legal demand are clamped. A strobe marks the first clock of each sub-cycle.

Top module: `subpwm_dac`

## Requirements
- R1: `sub_start_o` is high for exactly one clock in every `SUB_LEN` clocks. The clock right after reset is the first one, and it marks position 0 of a sub-cycle.
- R2: In each sub-cycle, `pwm_o` is high for the first w clocks and low for the remaining clocks. It is high at position 0 and low at position `SUB_LEN-1`, with exactly one rising edge (at position 0) and one falling edge.
- R3: The width w of every sub-cycle lies in the range 1 to `SUB_LEN-1`.
- R4: With a constant legal demand V, any 2^`SUB_LOG2` consecutive sub-cycles hold exactly 2^`SUB_LOG2` + V high clocks in total.
- R5: With a constant demand V, every width is either floor(V/2^`SUB_LOG2`)+1 or ceil(V/2^`SUB_LOG2`)+1.
- R6: A demand above (`SUB_LEN`-2)·2^`SUB_LOG2` is treated as exactly that value, so every later width is `SUB_LEN-1`.
- R7: The demand is sampled only on the last clock of a sub-cycle (position `SUB_LEN-1`). A value that is present only at other positions has no effect on any width.
- R8: Synchronous active-high reset clears the accumulator to 0, sets the position to 0 and makes the first sub-cycle's width 1.
- R9: A demand of 0 gives width 1 in every sub-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| demand_i | input | DEMAND_W | Requested level, unsigned, saturated above (SUB_LEN-2)·2^SUB_LOG2 |
| pwm_o | output | 1 | Pulse output bit |
| sub_start_o | output | 1 | High on the first clock of each sub-cycle |

## Verification
The bench targets the extremes of the demand range. A demand of zero must still give a one-clock pulse in every sub-cycle; a design that failed to add the extra clock would leave whole sub-cycles low and lose an edge pair. The top legal demand and values beyond it must give exactly `SUB_LEN-1` high clocks; a design without the clamp would either wrap to a narrow pulse or stay high across the boundary. The bench also checks that the accumulator restarts at zero after reset, because a stale residue shifts the pattern of wide and narrow pulses. Finally, it pulses the demand away from the boundary to catch a design that reads the demand on every clock.

// File: rtl/subpwm_pkg.sv
package subpwm_pkg;

    // Default geometry: 18-clock sub-cycles, 16 sub-cycles per full cycle.
    localparam int SUB_LEN_DEF  = 18;
    localparam int SUB_LOG2_DEF = 4;
    localparam int DEMAND_W_DEF = 10;

    // Output phase within a sub-cycle.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pulse_phase_e;

    // Largest legal demand for a given geometry.
    function automatic int demand_max(input int sub_len, input int sub_log2);
        return (sub_len - 2) * (1 << sub_log2);
    endfunction

endpackage

// File: rtl/subpwm_timer.sv
module subpwm_timer #(
    parameter int SUB_LEN = subpwm_pkg::SUB_LEN_DEF,
    localparam int POS_W  = $clog2(SUB_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [POS_W-1:0] pos_o,
    output logic             sub_start_o,
    output logic             boundary_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SUB_LEN - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            pos_q <= '0;
        else if (pos_q == LAST_POS)
            pos_q <= '0;
        else
            pos_q <= pos_q + POS_W'(1);
    end

    assign pos_o       = pos_q;
    assign sub_start_o = (pos_q == '0);
    assign boundary_o  = (pos_q == LAST_POS);

    // R1: the position returns to zero after the last clock of a sub-cycle
    a_r1_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        boundary_o |=> (pos_q == '0));
    // R1: the position advances by one elsewhere and never leaves the range
    a_r1_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !boundary_o |=> (pos_q == $past(pos_q) + POS_W'(1)) && (pos_q <= LAST_POS));

endmodule

// File: rtl/subpwm_accum.sv
module subpwm_accum #(
    parameter int SUB_LEN  = subpwm_pkg::SUB_LEN_DEF,
    parameter int SUB_LOG2 = subpwm_pkg::SUB_LOG2_DEF,
    parameter int DEMAND_W = subpwm_pkg::DEMAND_W_DEF,
    localparam int WID_W   = $clog2(SUB_LEN)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                boundary_i,
    input  logic [DEMAND_W-1:0] demand_i,
    output logic [WID_W-1:0]    width_o
);
    localparam int SUM_W = DEMAND_W + 1;
    localparam int X_W   = SUM_W - SUB_LOG2;
    localparam logic [DEMAND_W-1:0] VMAX = DEMAND_W'(subpwm_pkg::demand_max(SUB_LEN, SUB_LOG2));

    logic [SUB_LOG2-1:0] resid_q;
    logic [WID_W-1:0]    width_q;
    logic [DEMAND_W-1:0] v_sat;
    logic [SUM_W-1:0]    sum;
    logic [X_W-1:0]      whole;
    logic [WID_W-1:0]    width_d;

    always_comb begin
        v_sat   = (demand_i > VMAX) ? VMAX : demand_i;
        sum     = SUM_W'(resid_q) + SUM_W'(v_sat);
        whole   = sum[SUM_W-1:SUB_LOG2];
        width_d = WID_W'(whole) + WID_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            resid_q <= '0;
            width_q <= WID_W'(1);
        end else if (boundary_i) begin
            resid_q <= sum[SUB_LOG2-1:0];
            width_q <= width_d;
        end
    end

    assign width_o = width_q;

    // R3: width stays in range 1..SUB_LEN-1
    a_r3_width_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (width_q >= WID_W'(1)) && (width_q <= WID_W'(SUB_LEN - 1)));
    // R7: width changes only after a boundary clock
    a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !boundary_i |=> $stable(width_q));
    // R6: an over-range demand on a boundary gives the widest pulse
    a_r6_saturate: assert property (@(posedge clk_i) disable iff (rst_i)
        (boundary_i && (demand_i > VMAX)) |=> (width_q == WID_W'(SUB_LEN - 1)));

endmodule

// File: rtl/subpwm_shaper.sv
module subpwm_shaper #(
    parameter int SUB_LEN = subpwm_pkg::SUB_LEN_DEF,
    localparam int POS_W  = $clog2(SUB_LEN)
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] width_i,
    output logic             pwm_o
);
    import subpwm_pkg::*;

    pulse_phase_e phase;

    always_comb begin
        phase = (pos_i < width_i) ? PH_HIGH : PH_LOW;
        pwm_o = (phase == PH_HIGH);
    end

endmodule

// File: rtl/subpwm_dac.sv
module subpwm_dac #(
    parameter int SUB_LEN  = subpwm_pkg::SUB_LEN_DEF,
    parameter int SUB_LOG2 = subpwm_pkg::SUB_LOG2_DEF,
    parameter int DEMAND_W = subpwm_pkg::DEMAND_W_DEF
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [DEMAND_W-1:0] demand_i,
    output logic                pwm_o,
    output logic                sub_start_o
);
    localparam int POS_W = $clog2(SUB_LEN);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] width;
    logic             boundary;
    logic             start;

    subpwm_timer #(.SUB_LEN(SUB_LEN)) timer_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pos_o       (pos),
        .sub_start_o (start),
        .boundary_o  (boundary)
    );

    subpwm_accum #(
        .SUB_LEN  (SUB_LEN),
        .SUB_LOG2 (SUB_LOG2),
        .DEMAND_W (DEMAND_W)
    ) accum_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .boundary_i (boundary),
        .demand_i   (demand_i),
        .width_o    (width)
    );

    subpwm_shaper #(.SUB_LEN(SUB_LEN)) shaper_i (
        .pos_i   (pos),
        .width_i (width),
        .pwm_o   (pwm_o)
    );

    assign sub_start_o = start;

    // R2: every sub-cycle opens high
    a_r2_high_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
        start |-> pwm_o);
    // R2: every sub-cycle closes low
    a_r2_low_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
        boundary |-> !pwm_o);
    // R2: no rising edge except at the first position
    a_r2_single_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        !start |-> !$rose(pwm_o));

endmodule

// File: tb/subpwm_dac_tb_top.sv
module subpwm_dac_tb_top;
    localparam int L    = 18;
    localparam int SL2  = 4;
    localparam int S    = 1 << SL2;
    localparam int DW   = 10;
    localparam int VMAX = (L - 2) * S;
    localparam int VEC_N = 10;
    localparam int VEC [VEC_N] = '{0, 1, 5, 16, 100, 128, 255, 256, 300, 1023};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] demand = '0;
    logic          pwm;
    logic          sub_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    subpwm_dac #(.SUB_LEN(L), .SUB_LOG2(SL2), .DEMAND_W(DW)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .demand_i    (demand),
        .pwm_o       (pwm),
        .sub_start_o (sub_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sync();
        int n = 0;
        while (!sub_start && n < 4 * L) begin
            step();
            n++;
        end
    endtask

    // Observe one sub-cycle starting at position 0; ends at next position 0.
    task automatic run_sub(output int highs, output int chg, output bit first,
                           output bit last, output int bad_strobe);
        bit prev = 1'b0;
        highs = 0; chg = 0; first = 1'b0; last = 1'b0; bad_strobe = 0;
        for (int k = 0; k < L; k++) begin
            if (k == 0) first = pwm;
            else if (pwm != prev) chg++;
            if (k == L - 1) last = pwm;
            if (pwm) highs++;
            if ((k == 0) != sub_start) bad_strobe++;
            prev = pwm;
            step();
        end
    endtask

    task automatic check_shape(input int highs, input int chg, input bit first,
                               input bit last, input int bad_strobe);
        chk(first == 1'b1, "R2 high at start", int'(first), 1);
        chk(last == 1'b0, "R2 low at end", int'(last), 0);
        chk(chg == 1, "R2 one fall inside sub-cycle", chg, 1);
        chk(highs >= 1 && highs <= L - 1, "R3 width range", highs, L - 1);
        chk(bad_strobe == 0, "R1 strobe once per sub-cycle", bad_strobe, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        int h, c, bs, vs, lo, hi, total;
        bit f, la;

        // R8 / R1: reset state
        demand = '0;
        do_reset();
        chk(sub_start == 1'b1, "R1 strobe right after reset", int'(sub_start), 1);
        chk(pwm == 1'b1, "R8 first clock high", int'(pwm), 1);
        run_sub(h, c, f, la, bs);
        chk(h == 1, "R8 first width after reset", h, 1);

        // R8: accumulator starts at zero (demand S/2 -> widths 1,1,2,1,2...)
        demand = DW'(S / 2);
        do_reset();
        run_sub(h, c, f, la, bs);
        chk(h == 1, "R8 reset width", h, 1);
        run_sub(h, c, f, la, bs);
        chk(h == 1, "R8 residue zero first sample", h, 1);
        run_sub(h, c, f, la, bs);
        chk(h == 2, "R8 residue zero second sample", h, 2);

        // Vector table: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < VEC_N; i++) begin
            sync();
            demand = DW'(VEC[i]);
            run_sub(h, c, f, la, bs);
            vs = (VEC[i] > VMAX) ? VMAX : VEC[i];
            lo = vs / S + 1;
            hi = lo + ((vs % S) != 0 ? 1 : 0);
            total = 0;
            for (int j = 0; j < S; j++) begin
                run_sub(h, c, f, la, bs);
                check_shape(h, c, f, la, bs);
                chk(h == lo || h == hi, "R5 width choice", h, lo);
                if (VEC[i] == 0) chk(h == 1, "R9 zero demand width", h, 1);
                if (VEC[i] >= VMAX) chk(h == L - 1, "R6 saturated width", h, L - 1);
                total += h;
            end
            chk(total == S + vs, "R4 window total", total, S + vs);
        end

        // R7: demand pulse away from the boundary is ignored
        demand = '0;
        do_reset();
        run_sub(h, c, f, la, bs);
        for (int k = 0; k < L; k++) begin
            if (k == 4) demand = DW'(VMAX);
            if (k == 10) demand = '0;
            step();
        end
        run_sub(h, c, f, la, bs);
        chk(h == 1, "R7 mid-cycle demand ignored", h, 1);

        // R7: demand present on the boundary clock is taken
        for (int k = 0; k < L; k++) begin
            if (k == L - 1) demand = DW'(VMAX);
            step();
        end
        demand = '0;
        run_sub(h, c, f, la, bs);
        chk(h == L - 1, "R7 boundary demand taken", h, L - 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule